// File: doc/BRIEF.md
# Half-Bridge Shoot-Through Interlock

This block sits between a controller's gate commands and the gate-drive enables of one or more half-bridge legs. Each leg has a high-side and a low-side command; the block decodes each command according to a selectable input polarity and turns the decoded requests into two registered enables. It guarantees that the two switches of a leg are never enabled in the same cycle.

When both switches of a leg are requested together, one of two policies applies. Under the force-off policy both enables of that leg drop. Under the hold policy both enables keep the values they had before the conflicting request arrived, for as long as the conflict lasts. A kill input overrides everything and turns every switch off. A synchronous reset clears all enables.

Legs are independent: a conflict on one leg does not disturb the others. Polarity and policy are shared by all legs and are expected to stay static during operation.

Top module: `hb_interlock`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, every bit of `hi_en` and `lo_en` is 0 after that edge.
- R2: When exactly one of a leg's decoded requests is on, after the next edge that side's enable is 1 and the other side's enable is 0; when neither is on, both are 0.
- R3: With `cfg_hold` = 0 (force-off policy), a leg whose two decoded requests are both on has both enables at 0 after the next edge.
- R4: With `cfg_hold` = 1 (hold policy), a leg whose two decoded requests are both on keeps both enables unchanged across the edge, for every cycle the conflict lasts.
- R5: `cfg_hi_act_low` = 0 makes a 1 on `hi_cmd` a request for on and 1 makes a 0 a request for on; `cfg_lo_act_low` does the same for `lo_cmd`; the conflict rules of R3 and R4 apply to the decoded requests.
- R6: In no cycle are `hi_en[i]` and `lo_en[i]` both 1 for any leg i.
- R7: While `fault_kill` is 1 at an edge (and reset is not), all enables are 0 after that edge, under either policy and either polarity.
- R8: In the first cycle after a conflict on a leg ends, that leg's enables follow its decoded requests again, one edge later as in R2.
- R9: Each leg is resolved on its own: a conflict on one leg does not change the enables of another leg.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cfg_hi_act_low | input | 1 | 1: high-side commands are active low |
| cfg_lo_act_low | input | 1 | 1: low-side commands are active low |
| cfg_hold | input | 1 | Conflict policy: 0 force both off, 1 hold previous enables |
| fault_kill | input | 1 | Forces every enable off, highest priority |
| hi_cmd | input | N_LEGS | High-side command per leg, raw level |
| lo_cmd | input | N_LEGS | Low-side command per leg, raw level |
| hi_en | output | N_LEGS | Registered high-side gate enable per leg |
| lo_en | output | N_LEGS | Registered low-side gate enable per leg |

## Verification
The legs are driven through single-side requests, idle, and conflicts entered from a high-side-on state, from a low-side-on state and from all-off, so the hold policy is told apart from force-off and from a design that simply prefers one side. Each conflict is followed by a release, which separates proper return to following from a stuck hold. Active-low decoding is tried with each side inverted alone, which exposes a swapped or shared polarity control, and conflicts on one leg while a neighbour switches show that legs do not leak into each other; the kill input is applied in the middle of a held conflict to confirm its priority.

// File: rtl/hb_interlock_pkg.sv
package hb_interlock_pkg;

  typedef struct packed {
    logic hi;
    logic lo;
  } leg_drive_t;

  localparam leg_drive_t DRIVE_OFF = '{hi: 1'b0, lo: 1'b0};

  // Turn a raw command level into an on-request for the selected polarity.
  function automatic logic cmd_to_req(input logic level, input logic act_low);
    return act_low ? ~level : level;
  endfunction

  // Next enables of one leg from its decoded requests and present enables.
  function automatic leg_drive_t resolve_leg(input logic req_hi,
                                             input logic req_lo,
                                             input logic hold_mode,
                                             input logic kill,
                                             input leg_drive_t cur);
    leg_drive_t nxt;
    if (kill) begin
      nxt = DRIVE_OFF;
    end else if (req_hi && req_lo) begin
      nxt = hold_mode ? cur : DRIVE_OFF;
    end else begin
      nxt.hi = req_hi;
      nxt.lo = req_lo;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/hb_polarity.sv
module hb_polarity #(
  parameter int N_LEGS = 3
) (
  input  logic [N_LEGS-1:0] raw_cmd,
  input  logic              act_low,
  output logic [N_LEGS-1:0] req_on
);
  import hb_interlock_pkg::*;

  for (genvar g = 0; g < N_LEGS; g++) begin : g_bit
    assign req_on[g] = cmd_to_req(raw_cmd[g], act_low);
  end

endmodule

// File: rtl/hb_leg.sv
module hb_leg (
  input  logic clk,
  input  logic rst,
  input  logic req_hi,
  input  logic req_lo,
  input  logic hold_mode,
  input  logic kill,
  output logic hi_en,
  output logic lo_en,
  output logic conflict
);
  import hb_interlock_pkg::*;

  leg_drive_t drive_q;
  leg_drive_t drive_d;

  assign conflict = req_hi & req_lo;
  assign drive_d  = resolve_leg(req_hi, req_lo, hold_mode, kill, drive_q);

  always_ff @(posedge clk) begin
    if (rst) drive_q <= DRIVE_OFF;
    else     drive_q <= drive_d;
  end

  assign hi_en = drive_q.hi;
  assign lo_en = drive_q.lo;

endmodule

// File: rtl/hb_interlock.sv
module hb_interlock #(
  parameter int N_LEGS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_hi_act_low,
  input  logic              cfg_lo_act_low,
  input  logic              cfg_hold,
  input  logic              fault_kill,
  input  logic [N_LEGS-1:0] hi_cmd,
  input  logic [N_LEGS-1:0] lo_cmd,
  output logic [N_LEGS-1:0] hi_en,
  output logic [N_LEGS-1:0] lo_en
);

  logic [N_LEGS-1:0] req_hi_w;
  logic [N_LEGS-1:0] req_lo_w;
  logic [N_LEGS-1:0] conflict_w;

  hb_polarity #(.N_LEGS(N_LEGS)) u_pol_hi (
    .raw_cmd (hi_cmd),
    .act_low (cfg_hi_act_low),
    .req_on  (req_hi_w)
  );

  hb_polarity #(.N_LEGS(N_LEGS)) u_pol_lo (
    .raw_cmd (lo_cmd),
    .act_low (cfg_lo_act_low),
    .req_on  (req_lo_w)
  );

  for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
    hb_leg u_leg (
      .clk       (clk),
      .rst       (rst),
      .req_hi    (req_hi_w[g]),
      .req_lo    (req_lo_w[g]),
      .hold_mode (cfg_hold),
      .kill      (fault_kill),
      .hi_en     (hi_en[g]),
      .lo_en     (lo_en[g]),
      .conflict  (conflict_w[g])
    );
  end

endmodule

// File: rtl/hb_interlock_chk.sv
module hb_interlock_chk #(
  parameter int N_LEGS = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_hi_act_low,
  input logic              cfg_lo_act_low,
  input logic              cfg_hold,
  input logic              fault_kill,
  input logic [N_LEGS-1:0] hi_cmd,
  input logic [N_LEGS-1:0] lo_cmd,
  input logic [N_LEGS-1:0] hi_en,
  input logic [N_LEGS-1:0] lo_en,
  input logic [N_LEGS-1:0] conflict_w
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (hi_en == '0 && lo_en == '0));

  a_r7_kill_clears: assert property (@(posedge clk) disable iff (rst)
    fault_kill |=> (hi_en == '0 && lo_en == '0));

  for (genvar g = 0; g < N_LEGS; g++) begin : g_chk
    a_r6_no_shoot_through: assert property (@(posedge clk) disable iff (rst)
      !(hi_en[g] && lo_en[g]));

    a_r3_force_off: assert property (@(posedge clk) disable iff (rst)
      (conflict_w[g] && !cfg_hold) |=> (!hi_en[g] && !lo_en[g]));

    a_r4_hold_state: assert property (@(posedge clk) disable iff (rst)
      (conflict_w[g] && cfg_hold && !fault_kill) |=> ($stable(hi_en[g]) && $stable(lo_en[g])));

    // R2, R5, R8: outside a conflict the enables follow the decoded commands.
    a_r2_follow: assert property (@(posedge clk) disable iff (rst)
      (!conflict_w[g] && !fault_kill)
      |=> (hi_en[g] == $past(hi_cmd[g] ^ cfg_hi_act_low)
        && lo_en[g] == $past(lo_cmd[g] ^ cfg_lo_act_low)));
  end

endmodule

bind hb_interlock hb_interlock_chk #(.N_LEGS(N_LEGS)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cfg_hi_act_low (cfg_hi_act_low),
  .cfg_lo_act_low (cfg_lo_act_low),
  .cfg_hold       (cfg_hold),
  .fault_kill     (fault_kill),
  .hi_cmd         (hi_cmd),
  .lo_cmd         (lo_cmd),
  .hi_en          (hi_en),
  .lo_en          (lo_en),
  .conflict_w     (conflict_w)
);

// File: tb/hb_interlock_tb_top.sv
`timescale 1ns/1ps
module hb_interlock_tb_top;

  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_hi_act_low = 1'b0;
  logic         cfg_lo_act_low = 1'b0;
  logic         cfg_hold = 1'b0;
  logic         fault_kill = 1'b0;
  logic [N-1:0] hi_cmd = '0;
  logic [N-1:0] lo_cmd = '0;
  logic [N-1:0] hi_en;
  logic [N-1:0] lo_en;

  logic [N-1:0] m_hi = '0;
  logic [N-1:0] m_lo = '0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hb_interlock #(.N_LEGS(N)) dut_i (
    .clk(clk), .rst(rst), .cfg_hi_act_low(cfg_hi_act_low),
    .cfg_lo_act_low(cfg_lo_act_low), .cfg_hold(cfg_hold),
    .fault_kill(fault_kill), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
    .hi_en(hi_en), .lo_en(lo_en)
  );

  // Expected enables from the requirements, evaluated at each edge.
  task automatic model_edge();
    logic [N-1:0] rh, rl;
    rh = cfg_hi_act_low ? ~hi_cmd : hi_cmd;
    rl = cfg_lo_act_low ? ~lo_cmd : lo_cmd;
    for (int i = 0; i < N; i++) begin
      if (rst || fault_kill) begin
        m_hi[i] = 1'b0; m_lo[i] = 1'b0;
      end else if (rh[i] && rl[i]) begin
        if (!cfg_hold) begin m_hi[i] = 1'b0; m_lo[i] = 1'b0; end
      end else begin
        m_hi[i] = rh[i]; m_lo[i] = rl[i];
      end
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (hi_en !== m_hi || lo_en !== m_lo) begin
      errors++;
      $display("FAIL %s: hi_en=%b lo_en=%b expected hi_en=%b lo_en=%b",
               tag, hi_en, lo_en, m_hi, m_lo);
    end
    checks++;
    if ((hi_en & lo_en) != '0) begin
      errors++;
      $display("FAIL R6: both enables on, hi_en=%b lo_en=%b expected overlap=000",
               hi_en, lo_en);
    end
  endtask

  // Called at a falling edge: apply commands, pass one rising edge, check.
  task automatic step(input logic [N-1:0] h, input logic [N-1:0] l, input string tag);
    hi_cmd = h;
    lo_cmd = l;
    @(posedge clk);
    model_edge();
    #1;
    compare(tag);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(3'b111, 3'b000, "R1 reset with commands on");
    step(3'b000, 3'b101, "R1 reset holds off");
    rst = 1'b0;
  endtask

  task automatic t_single();
    cfg_hold = 1'b0; cfg_hi_act_low = 1'b0; cfg_lo_act_low = 1'b0;
    step(3'b001, 3'b010, "R2 single requests");
    step(3'b100, 3'b001, "R2 side swap");
    step(3'b000, 3'b000, "R2 idle");
  endtask

  task automatic t_force_off();
    cfg_hold = 1'b0;
    step(3'b011, 3'b100, "R2 setup before conflict");
    step(3'b111, 3'b111, "R3 all legs conflict");
    step(3'b111, 3'b111, "R3 conflict persists");
    step(3'b010, 3'b001, "R8 release after force-off");
  endtask

  task automatic t_hold();
    cfg_hold = 1'b1;
    step(3'b001, 3'b010, "R2 setup hi leg0 lo leg1");
    step(3'b111, 3'b111, "R4 hold from mixed state");
    step(3'b111, 3'b111, "R4 hold persists");
    step(3'b111, 3'b111, "R4 hold third cycle");
    step(3'b100, 3'b000, "R8 release after hold");
    step(3'b000, 3'b000, "R4 idle before conflict from off");
    step(3'b010, 3'b010, "R4 hold from all off");
  endtask

  task automatic t_active_low();
    cfg_hold = 1'b0;
    cfg_hi_act_low = 1'b1; cfg_lo_act_low = 1'b0;
    step(3'b110, 3'b000, "R5 high side inverted");
    step(3'b011, 3'b100, "R5 inverted hi conflict on leg2");
    cfg_hi_act_low = 1'b0; cfg_lo_act_low = 1'b1;
    step(3'b000, 3'b101, "R5 low side inverted");
    cfg_hi_act_low = 1'b1; cfg_lo_act_low = 1'b1;
    cfg_hold = 1'b1;
    step(3'b101, 3'b111, "R5 both inverted");
    step(3'b000, 3'b000, "R5 both inverted hold conflict");
    step(3'b111, 3'b111, "R5 both inverted idle");
    cfg_hi_act_low = 1'b0; cfg_lo_act_low = 1'b0;
  endtask

  task automatic t_fault();
    cfg_hold = 1'b1;
    step(3'b101, 3'b010, "R2 setup before kill");
    step(3'b111, 3'b111, "R4 hold before kill");
    fault_kill = 1'b1;
    step(3'b111, 3'b111, "R7 kill during hold");
    step(3'b001, 3'b100, "R7 kill with single requests");
    fault_kill = 1'b0;
    step(3'b111, 3'b111, "R7 hold after kill stays off");
    step(3'b001, 3'b100, "R8 follow after kill");
  endtask

  task automatic t_legs();
    cfg_hold = 1'b0;
    step(3'b001, 3'b100, "R9 setup");
    step(3'b011, 3'b110, "R9 conflict leg1 only");
    cfg_hold = 1'b1;
    step(3'b101, 3'b011, "R9 hold conflict leg0 others move");
    step(3'b101, 3'b111, "R9 conflicts leg0 leg2");
  endtask

  task automatic t_reset_mid();
    step(3'b010, 3'b001, "R2 before mid reset");
    rst = 1'b1;
    step(3'b010, 3'b001, "R1 mid-run reset");
    rst = 1'b0;
    step(3'b111, 3'b111, "R4 hold right after reset");
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_force_off();
    t_hold();
    t_active_low();
    t_fault();
    t_legs();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule